// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller with Selectable Write Policies

This block is a small direct-mapped data cache. It sits between a processor request port and a lower-level memory port. It holds the tags, a valid bit for each word, a modified bit for each line, and the data words. A processor read or write is accepted only when the controller is idle. A completion pulse marks the end of each access, and the read data is presented with that pulse.

Two inputs set the write policy, and they are sampled together with each request.
- The write-hit policy chooses between write-through and write-back.
- The write-miss policy is built from three separate choices: fetch on write, allocate on write and invalidate on write. Four working combinations are offered.

Because each word has its own valid bit, a line can be partly valid without ever having been fetched. When such a line is later read or evicted, this is taken into account.

The lower-level port moves whole lines. Every transfer carries a line address, a line-wide data bus and a per-word write mask. The request is held until the memory signals ready.

Top module: `wp_cache`

## Requirements
- R1: Synchronous active-high reset clears every valid and modified bit. After reset the controller is idle with `req_ready` high and no memory request, and the first read of any address fetches from memory.
- R2: A read whose tag matches and whose word is valid returns the stored word with no memory transfer.
- R3: Any other read issues one line-wide memory read at the line address `req_addr[9:2]`. If a modified line with another tag occupies the slot, that line is first written out to the lower level. On a fill of a line whose tag already matches, the words that are already valid are kept and only the invalid words are taken from memory.
- R4: With `wb_mode`=0 (write-through), a write that finds its line present updates the cache and issues one memory write. That write has exactly one mask bit set, bit k for word k, with the data in `mem_wdata[32k+31:32k]`. Lines never become modified in this mode.
- R5: With `wb_mode`=1 (write-back), a write that finds its line present makes no memory transfer and marks the line modified. The new data reaches memory only when the line is replaced, as one line write whose mask equals the line's valid words.
- R6: `miss_mode`=0 (fetch on write): a write miss fetches the whole line, merges the written word into it, and then completes under the write-hit policy.
- R7: `miss_mode`=1 (write-validate): a write miss allocates the line without any fetch, and only the written word is valid.
- R8: `miss_mode`=2 (write-around): a write miss sends the word to memory and leaves the cache unchanged.
- R9: `miss_mode`=3 (write-invalidate): a write miss marks the indexed line invalid and sends the word to memory. A modified victim is written out first.
- R10: One access at a time: `req_ready` falls after an accept and stays low until `req_done`, which lasts exactly one cycle.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_ready` completes the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_mode | input | 1 | 1 = write-back, 0 = write-through (sampled at accept) |
| miss_mode | input | 2 | Write-miss policy (0 fetch, 1 validate, 2 around, 3 invalidate) |
| req_valid | input | 1 | Processor request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address: [1:0] word in line, [4:2] index, [9:5] tag |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with req_done |
| mem_req | output | 1 | Lower-level transfer request |
| mem_we | output | 1 | 1 = write transfer |
| mem_addr | output | 8 | Line address |
| mem_wdata | output | 128 | Line write data, word k at bits 32k+31:32k |
| mem_wmask | output | 4 | Per-word write enable |
| mem_ready | input | 1 | Lower level completes the transfer |
| mem_rdata | input | 128 | Line read data |

## Verification
The bench builds the block with its default sizes: eight lines of four 32-bit words over a 10-bit word address space. These sizes make it cheap to aim several tags at one index, so victim write-out, partial-line merging and the masked eviction of a partly valid line all happen within a few accesses. The policy inputs are sampled with each request, so this one build steps through both write-hit policies and all four write-miss policies. For each access the bench compares the counts of memory reads and writes and the contents of the modelled lower level against what the active policy predicts.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    localparam int WORD_W  = 32;
    localparam int WORDS   = 4;
    localparam int LINES   = 8;
    localparam int ADDR_W  = 10;
    localparam int OFF_W   = $clog2(WORDS);
    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int LINE_W  = WORD_W * WORDS;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [WORDS-1:0][WORD_W-1:0] ldata_t;

    typedef enum logic [1:0] {
        MISS_FETCH    = 2'd0,
        MISS_VALIDATE = 2'd1,
        MISS_AROUND   = 2'd2,
        MISS_INVAL    = 2'd3
    } miss_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [WORDS-1:0] wval;
        logic             dirty;
        ldata_t           data;
    } line_t;

    typedef struct packed {
        logic             write;
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
        word_t            wdata;
        logic             wb;
        miss_e            miss;
    } req_t;

    typedef enum logic [2:0] {
        S_IDLE, S_LOOK, S_EVICT, S_FILL, S_WRMEM, S_DONE
    } st_e;

    function automatic ldata_t put_word(ldata_t d, logic [OFF_W-1:0] o, word_t w);
        ldata_t r;
        r    = d;
        r[o] = w;
        return r;
    endfunction

    function automatic logic [WORDS-1:0] word_bit(logic [OFF_W-1:0] o);
        logic [WORDS-1:0] r;
        r    = '0;
        r[o] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/wpc_store.sv
module wpc_store
    import wpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output line_t            rd_line,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_t            wr_line
);
    line_t lines_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                lines_q[g].wval  <= '0;
                lines_q[g].dirty <= 1'b0;
            end else if (we && wr_idx == IDX_W'(g)) begin
                lines_q[g] <= wr_line;
            end
        end

        // R1
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> (lines_q[g].wval == '0 && !lines_q[g].dirty));
    end

    assign rd_line = lines_q[rd_idx];

    // R5
    dirty_has_data_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wr_line.dirty) |-> (|wr_line.wval));
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wb_mode,
    input  logic [1:0]         miss_mode,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  word_t              req_wdata,
    output logic               req_ready,
    output logic               req_done,
    output word_t              rsp_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [LADDR_W-1:0] mem_addr,
    output ldata_t             mem_wdata,
    output logic [WORDS-1:0]   mem_wmask,
    input  logic               mem_ready,
    input  ldata_t             mem_rdata,
    output logic [IDX_W-1:0]   st_idx,
    input  line_t              line,
    output logic               st_we,
    output line_t              st_line
);
    st_e   st_q, st_d;
    req_t  rq_q;
    word_t rdata_q, rdata_d;
    logic  present, hit_word, victim_out;
    line_t fill_l, hit_l, alloc_l;

    assign st_idx   = rq_q.idx;
    assign present  = (|line.wval) && (line.tag == rq_q.tag);
    assign hit_word = present && line.wval[rq_q.off];
    // a modified line of another tag must leave before its slot is reused
    assign victim_out = !present && line.dirty &&
                        !(rq_q.write && rq_q.miss == MISS_AROUND);

    always_comb begin
        fill_l       = line;
        fill_l.tag   = rq_q.tag;
        fill_l.wval  = '1;
        fill_l.dirty = present && line.dirty;
        for (int k = 0; k < WORDS; k++)
            fill_l.data[k] = (present && line.wval[k]) ? line.data[k] : mem_rdata[k];
        if (rq_q.write) begin
            fill_l.data  = put_word(fill_l.data, rq_q.off, rq_q.wdata);
            fill_l.dirty = fill_l.dirty | rq_q.wb;
        end
    end

    always_comb begin
        hit_l        = line;
        hit_l.data   = put_word(line.data, rq_q.off, rq_q.wdata);
        hit_l.wval   = line.wval | word_bit(rq_q.off);
        hit_l.dirty  = line.dirty | rq_q.wb;
        alloc_l      = hit_l;
        alloc_l.tag  = rq_q.tag;
        alloc_l.wval = word_bit(rq_q.off);
        alloc_l.dirty = rq_q.wb;
    end

    always_comb begin
        st_d      = st_q;
        rdata_d   = rdata_q;
        st_we     = 1'b0;
        st_line   = line;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {rq_q.tag, rq_q.idx};
        mem_wdata = line.data;
        mem_wmask = line.wval;
        unique case (st_q)
            S_IDLE: if (req_valid) st_d = S_LOOK;
            S_LOOK: begin
                if (victim_out) begin
                    st_d = S_EVICT;
                end else if (!rq_q.write) begin
                    if (hit_word) begin
                        rdata_d = line.data[rq_q.off];
                        st_d    = S_DONE;
                    end else begin
                        st_d = S_FILL;
                    end
                end else if (present) begin
                    st_we   = 1'b1;
                    st_line = hit_l;
                    st_d    = rq_q.wb ? S_DONE : S_WRMEM;
                end else begin
                    unique case (rq_q.miss)
                        MISS_FETCH:    st_d = S_FILL;
                        MISS_VALIDATE: begin
                            st_we   = 1'b1;
                            st_line = alloc_l;
                            st_d    = rq_q.wb ? S_DONE : S_WRMEM;
                        end
                        MISS_AROUND:   st_d = S_WRMEM;
                        MISS_INVAL:    begin
                            st_we         = 1'b1;
                            st_line.wval  = '0;
                            st_line.dirty = 1'b0;
                            st_d          = S_WRMEM;
                        end
                    endcase
                end
            end
            S_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {line.tag, rq_q.idx};
                if (mem_ready) begin
                    st_we         = 1'b1;
                    st_line.dirty = 1'b0;
                    st_d          = S_LOOK;
                end
            end
            S_FILL: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    st_we   = 1'b1;
                    st_line = fill_l;
                    rdata_d = fill_l.data[rq_q.off];
                    st_d    = (rq_q.write && !rq_q.wb) ? S_WRMEM : S_DONE;
                end
            end
            S_WRMEM: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = put_word('0, rq_q.off, rq_q.wdata);
                mem_wmask = word_bit(rq_q.off);
                if (mem_ready) st_d = S_DONE;
            end
            S_DONE: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            rq_q    <= '0;
            rdata_q <= '0;
        end else begin
            st_q    <= st_d;
            rdata_q <= rdata_d;
            if (st_q == S_IDLE && req_valid)
                rq_q <= '{write: req_write,
                          tag:   req_addr[ADDR_W-1 -: TAG_W],
                          idx:   req_addr[OFF_W +: IDX_W],
                          off:   req_addr[OFF_W-1:0],
                          wdata: req_wdata,
                          wb:    wb_mode,
                          miss:  miss_e'(miss_mode)};
        end
    end

    assign req_ready = (st_q == S_IDLE);
    assign req_done  = (st_q == S_DONE);
    assign rsp_rdata = rdata_q;

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done);
    // R2
    hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_LOOK && !rq_q.write && hit_word) |=> !mem_req);
    // R4
    single_word_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && st_q == S_WRMEM) |-> ($countones(mem_wmask) == 1));
endmodule

// File: rtl/wp_cache.sv
module wp_cache
    import wpc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wb_mode,
    input  logic [1:0]         miss_mode,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               req_done,
    output logic [WORD_W-1:0]  rsp_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [LADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0]  mem_wdata,
    output logic [WORDS-1:0]   mem_wmask,
    input  logic               mem_ready,
    input  logic [LINE_W-1:0]  mem_rdata
);
    logic [IDX_W-1:0] st_idx;
    line_t            rd_line, st_line;
    logic             st_we;
    ldata_t           wdata_l;

    assign mem_wdata = wdata_l;

    wpc_store u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (st_idx),
        .rd_line (rd_line),
        .we      (st_we),
        .wr_idx  (st_idx),
        .wr_line (st_line)
    );

    wpc_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wb_mode   (wb_mode),
        .miss_mode (miss_mode),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .req_done  (req_done),
        .rsp_rdata (rsp_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (wdata_l),
        .mem_wmask (mem_wmask),
        .mem_ready (mem_ready),
        .mem_rdata (ldata_t'(mem_rdata)),
        .st_idx    (st_idx),
        .line      (rd_line),
        .st_we     (st_we),
        .st_line   (st_line)
    );
endmodule

// File: tb/wp_cache_bench.sv
module wp_cache_bench;
    localparam int MEMW = 1024;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wb_mode = 1'b1;
    logic [1:0]   miss_mode = 2'd0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [9:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         req_ready, req_done;
    logic [31:0]  rsp_rdata;
    logic         mem_req, mem_we;
    logic [7:0]   mem_addr;
    logic [127:0] mem_wdata, mem_rdata;
    logic [3:0]   mem_wmask;
    logic         mem_ready;

    logic [31:0] lower  [MEMW];
    logic [31:0] golden [MEMW];
    int n_rd, n_wr, n_done, rd0, wr0;
    int errors = 0, checks = 0;
    bit ended = 0;
    logic [31:0] exp_q[$];
    bit          isrd_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    wp_cache u_wp_cache (
        .clk(clk), .rst(rst), .wb_mode(wb_mode), .miss_mode(miss_mode),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .req_done(req_done),
        .rsp_rdata(rsp_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] seed(int i);
        return 32'h5A00_0000 ^ (i * 32'h0001_0003);
    endfunction

    function automatic int A(int tag, int idx, int off);
        return tag * 32 + idx * 4 + off;
    endfunction

    // lower-level memory model: ready one cycle after a request is seen
    always @(posedge clk) begin
        if (rst) begin
            mem_ready <= 1'b0;
            n_rd <= 0;
            n_wr <= 0;
            for (int i = 0; i < MEMW; i++) lower[i] <= seed(i);
        end else begin
            mem_ready <= mem_req && !mem_ready;
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    n_wr <= n_wr + 1;
                    for (int k = 0; k < 4; k++)
                        if (mem_wmask[k]) lower[int'(mem_addr) * 4 + k] <= mem_wdata[k*32 +: 32];
                end else begin
                    n_rd <= n_rd + 1;
                end
            end
        end
    end

    always_comb
        for (int k = 0; k < 4; k++) mem_rdata[k*32 +: 32] = lower[int'(mem_addr) * 4 + k];

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // monitor: pops scoreboard entries on completion
    always @(negedge clk) begin
        if (!rst && req_done) begin
            n_done = n_done + 1;
            if (exp_q.size() == 0) begin
                chk("R10 unexpected done", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                bit   rdop;
                string t;
                e = exp_q.pop_front();
                rdop = isrd_q.pop_front();
                t = tag_q.pop_front();
                if (rdop) chk(t, rsp_rdata, e);
            end
        end
    end

    // R11 bench-side hold check
    logic       p_req, p_rdy;
    logic [7:0] p_addr;
    always @(negedge clk) begin
        if (!rst && p_req && !p_rdy) chk("R11 mem hold", {24'd0, mem_addr} | {31'd0, ~mem_req},
                                         {24'd0, p_addr});
        p_req = mem_req; p_rdy = mem_ready; p_addr = mem_addr;
    end

    task automatic op(string r, bit wr, int a, logic [31:0] d, bit wb, int mm);
        int c;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = 10'(a);
        req_wdata = d; wb_mode = wb; miss_mode = 2'(mm);
        exp_q.push_back(wr ? 32'd0 : golden[a]);
        isrd_q.push_back(!wr);
        tag_q.push_back(r);
        if (wr) golden[a] = d;
        rd0 = n_rd; wr0 = n_wr; c = n_done;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 busy after accept", {31'd0, req_ready}, 32'd0);
        while (n_done == c) @(negedge clk);
    endtask

    task automatic traffic(string r, int er, int ew);
        chk({r, " mem reads"}, n_rd - rd0, er);
        chk({r, " mem writes"}, n_wr - wr0, ew);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        n_done = 0;
        for (int i = 0; i < MEMW; i++) golden[i] = seed(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1 no mem req", {31'd0, mem_req}, 32'd0);
        chk("R10 no done", {31'd0, req_done}, 32'd0);

        op("R1 cold read", 0, A(1,0,0), 0, 1, 0);           traffic("R1", 1, 0);
        op("R2 read hit", 0, A(1,0,1), 0, 1, 0);            traffic("R2", 0, 0);
        op("R5 wb write hit", 1, A(1,0,2), 32'hCAFE0001, 1, 0); traffic("R5", 0, 0);
        chk("R5 memory stale", lower[A(1,0,2)], seed(A(1,0,2)));
        op("R2 read written", 0, A(1,0,2), 0, 1, 0);        traffic("R2", 0, 0);
        op("R3 dirty victim", 0, A(2,0,0), 0, 1, 0);        traffic("R3", 1, 1);
        chk("R5 written back", lower[A(1,0,2)], 32'hCAFE0001);
        op("R4 wt write hit", 1, A(2,0,1), 32'hBEEF0002, 0, 0); traffic("R4", 0, 1);
        chk("R4 memory updated", lower[A(2,0,1)], 32'hBEEF0002);

        op("R6 fetch write miss", 1, A(3,1,0), 32'h1111_0003, 1, 0); traffic("R6", 1, 0);
        chk("R6 memory stale", lower[A(3,1,0)], seed(A(3,1,0)));
        op("R6 rest of line", 0, A(3,1,3), 0, 1, 0);        traffic("R6", 0, 0);

        op("R7 validate miss", 1, A(4,2,1), 32'h2222_0004, 1, 1); traffic("R7", 0, 0);
        op("R7 written word hit", 0, A(4,2,1), 0, 1, 1);    traffic("R7", 0, 0);
        op("R3 partial fill", 0, A(4,2,0), 0, 1, 1);        traffic("R3", 1, 0);
        op("R3 merge keeps word", 0, A(4,2,1), 0, 1, 1);    traffic("R3", 0, 0);
        op("R5 evict merged", 0, A(5,2,0), 0, 1, 1);        traffic("R5", 1, 1);
        chk("R5 evicted word", lower[A(4,2,1)], 32'h2222_0004);

        op("R7 validate miss 2", 1, A(6,3,2), 32'h3333_0006, 1, 1); traffic("R7", 0, 0);
        op("R5 partial evict", 0, A(7,3,0), 0, 1, 1);       traffic("R5", 1, 1);
        chk("R5 masked word written", lower[A(6,3,2)], 32'h3333_0006);
        chk("R5 invalid word untouched", lower[A(6,3,1)], seed(A(6,3,1)));

        op("R8 prime", 0, A(8,4,0), 0, 1, 2);               traffic("R8", 1, 0);
        op("R8 around miss", 1, A(9,4,0), 32'h4444_0009, 1, 2); traffic("R8", 0, 1);
        chk("R8 memory direct", lower[A(9,4,0)], 32'h4444_0009);
        op("R8 cache unchanged", 0, A(8,4,1), 0, 1, 2);     traffic("R8", 0, 0);
        op("R8 reread misses", 0, A(9,4,0), 0, 1, 2);       traffic("R8", 1, 0);

        op("R9 invalidate miss", 1, A(10,4,0), 32'h5555_000A, 1, 3); traffic("R9", 0, 1);
        chk("R9 memory direct", lower[A(10,4,0)], 32'h5555_000A);
        op("R9 line gone", 0, A(9,4,1), 0, 1, 3);           traffic("R9", 1, 0);
        op("R5 dirty for inval", 1, A(9,4,2), 32'h6666_0009, 1, 3); traffic("R5", 0, 0);
        op("R9 dirty victim", 1, A(12,4,0), 32'h7777_000C, 1, 3); traffic("R9", 0, 2);
        chk("R9 victim saved", lower[A(9,4,2)], 32'h6666_0009);
        op("R9 refetch victim", 0, A(9,4,2), 0, 1, 3);      traffic("R9", 1, 0);

        op("R7 wt validate", 1, A(13,5,0), 32'h8888_000D, 0, 1); traffic("R7", 0, 1);
        op("R7 wt hit", 0, A(13,5,0), 0, 0, 1);             traffic("R7", 0, 0);
        op("R4 clean replace", 0, A(14,5,0), 0, 0, 1);      traffic("R4", 1, 0);
        op("R6 wt fetch miss", 1, A(15,6,3), 32'h9999_000F, 0, 0); traffic("R6", 1, 1);
        chk("R6 wt memory", lower[A(15,6,3)], 32'h9999_000F);
        op("R6 wt read back", 0, A(15,6,3), 0, 0, 0);       traffic("R6", 0, 0);

        repeat (3) @(negedge clk);
        chk("R10 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule